// File: doc/BRIEF.md
# PCI Type-0 Configuration Header

This block holds the 64-byte type-0 configuration header of a PCI endpoint. Configuration software reaches it through a plain dword-addressed port: a 4-bit dword index, four byte enables, a write strobe with write data, and read data that follows the index combinationally. Identity values (vendor, device, revision, class code, subsystem and interrupt pin) and the capability presence are fixed at elaboration through parameters. The command register keeps only its defined control bits, and the status register clears its error flags on write-one.

Six base address slots are configured by parameter as unused, 32-bit memory, 64-bit memory or I/O, each with a region size in bytes. The size is rounded up to a power of two, with a floor of 4 KiB for memory and 4 bytes for I/O. Each slot stores only the address bits above that size, so software can size a region by writing all ones and reading back. A 64-bit memory slot takes the following slot as its upper address dword. For each slot the block drives a decode-enable bit and a 64-bit base address, which downstream address decoders use to claim accesses.

Top module: `cfg_hdr_t0`

## Requirements
- R1: In the command half of dword 1, writes change only bits 10, 8, 6, 2, 1 and 0, each byte gated by its byte enable. Every other command bit reads 0.
- R2: Status bits 15, 14, 13, 12, 11 and 8 are set by the `err_evt` pulses, with bits [0..5] of `err_evt` mapped to status bits 8, 11, 12, 13, 14 and 15. A write of 1 to one of these bits in dword 1 [31:16], with its byte enabled, clears it. A write of 0 leaves it unchanged. When a set and a clear hit the same bit in the same cycle, the set wins. No other status bit can be changed by a write.
- R3: With `HAS_CAP` set, status bit 4 reads 1 and dword 13 [7:0] (offset 0x34) reads 0x40. With `HAS_CAP` clear, both read 0.
- R4: For each slot, the writable mask is ~(size-1), where size is the region size rounded up to a power of two, with a floor of 4 KiB for memory and 4 bytes for I/O. A full write stores new = (old & ~mask) | (data & mask). An all-ones write reads back the mask combined with the type bits.
- R5: The type bits are read-only. An I/O slot reads bit 0 = 1. A memory slot reads bits [2:1] = 00 for 32-bit or 10 for 64-bit, and bit 3 = prefetchable.
- R6: The slot after a 64-bit memory slot holds the upper 32 address bits. Its writable mask is bits [63:32] of the 64-bit size mask.
- R7: A write to a slot dword (indices 4 to 9) with any byte enable clear is ignored.
- R8: An unused slot reads 0 and ignores writes.
- R9: `bar_en[i]` is 1 when slot i is I/O and command bit 0 is set, or when slot i is a 32-bit or 64-bit memory slot and command bit 1 is set. Otherwise it is 0, which includes unused and upper slots. `bar_base[64*i +: 64]` is the slot's address with the type bits cleared, and it carries the upper dword for 64-bit memory slots. Both outputs reflect a write from the clock edge that takes the write.
- R10: Reset sets the command register to 0, clears the status error bits and returns each slot to its type bits only, so every `bar_en` is 0.
- R11: The expansion ROM dword (12) and every unimplemented dword read 0 and ignore writes.
- R12: The identity dwords read the parameter values: dword 0 = {device, vendor}, dword 2 = {class code, revision}, dword 11 = {subsystem, subsystem vendor}, and dword 15 [15:8] = interrupt pin. Writes to these dwords are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Write strobe, taken at the rising clock edge |
| cfg_dw_addr | input | 4 | Dword index into the header |
| cfg_byte_en | input | 4 | Byte enables of the write |
| cfg_wr_data | input | 32 | Write data |
| cfg_rd_data | output | 32 | Read data for `cfg_dw_addr`, combinational |
| err_evt | input | 6 | One-cycle pulses that set the status error bits |
| bar_en | output | 6 | Decode enable per slot |
| bar_base | output | 384 | 64-bit base address per slot, slot i at [64*i +: 64] |

## Verification
The vector table probes every slot with all ones and checks the mask readback for each kind: 32-bit memory at the 4 KiB floor, an odd-sized I/O region, the lower and upper dwords of a prefetchable 64-bit pair, an unused slot, and a 2-byte I/O region at the 4-byte floor. This separates a missing size floor, bad rounding or wrong pairing from a correct mask. Writes of zero, a mixed pattern and partial byte enables separate masked merging from a blind store or a missing dword-width check. Directed tests step the command between memory-only and I/O-only to show which enables follow which command bit. They also pulse error events against one-to-clear writes, including a set and a clear on the same bit in the same cycle, and apply reset in the middle of the run.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

   // slot kinds
   typedef enum logic [1:0] {
      BK_NONE  = 2'd0,
      BK_MEM32 = 2'd1,
      BK_MEM64 = 2'd2,
      BK_IO    = 2'd3
   } bar_kind_e;

   localparam int NBAR       = 6;
   localparam int HDR_DW     = 16;
   localparam int DW_AW      = $clog2(HDR_DW);
   localparam int BAR_DW0    = 4;
   localparam int MEM_MIN_LG = 12;
   localparam int IO_MIN_LG  = 2;

   localparam logic [15:0] CMD_WMASK = 16'h0547;
   localparam logic [15:0] STAT_W1C  = 16'hF900;
   localparam logic [7:0]  CAP_START = 8'h40;

   // 64-bit writable mask of a region, size rounded up with a floor
   function automatic logic [63:0] span_mask(bar_kind_e k, logic [63:0] bytes);
      int lg;
      lg = $clog2(bytes);
      if (k == BK_IO) begin
         if (lg < IO_MIN_LG) lg = IO_MIN_LG;
      end else begin
         if (lg < MEM_MIN_LG) lg = MEM_MIN_LG;
      end
      if (k == BK_NONE) return 64'd0;
      return ~((64'd1 << lg) - 64'd1);
   endfunction

   // read-only low bits that tell the slot kind
   function automatic logic [31:0] kind_bits(bar_kind_e k, logic pref);
      case (k)
         BK_IO:    return 32'h1;
         BK_MEM32: return {28'd0, pref, 3'b000};
         BK_MEM64: return {28'd0, pref, 3'b100};
         default:  return 32'h0;
      endcase
   endfunction

endpackage

// File: rtl/cfg_cmd_stat.sv
module cfg_cmd_stat
   import cfg_hdr_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr,
   input  logic [3:0]  be,
   input  logic [31:0] wd,
   input  logic [5:0]  err_evt,
   output logic [15:0] cmd_q,
   output logic [15:0] stat_q
);

   logic [15:0] cmd_bm;
   logic [15:0] stat_clr;
   logic [15:0] stat_set;
   logic [15:0] cmd_d;
   logic [15:0] stat_d;

   always_comb begin
      cmd_bm   = {{8{be[1]}}, {8{be[0]}}} & CMD_WMASK;
      stat_clr = wd[31:16] & {{8{be[3]}}, {8{be[2]}}} & STAT_W1C;
      stat_set = {err_evt[5], err_evt[4], err_evt[3], err_evt[2], err_evt[1],
                  2'b00, err_evt[0], 8'h00};
      cmd_d    = cmd_q;
      stat_d   = stat_q;
      if (wr) begin
         cmd_d  = (cmd_q & ~cmd_bm) | (wd[15:0] & cmd_bm);
         stat_d = stat_q & ~stat_clr;
      end
      stat_d = stat_d | stat_set;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q  <= '0;
         stat_q <= '0;
      end else begin
         cmd_q  <= cmd_d;
         stat_q <= stat_d;
      end
   end

   // R1
   cmd_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_q & ~CMD_WMASK) == 16'h0);

   // R2
   stat_noset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_evt == 6'd0) |=> ((stat_q & ~$past(stat_q)) == 16'h0));

   // R2
   stat_only_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q & ~STAT_W1C) == 16'h0);

   // R10
   rst_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (cmd_q == 16'h0));

endmodule

// File: rtl/cfg_bar_slot.sv
module cfg_bar_slot #(
   parameter logic [31:0] MASK = 32'hFFFF_F000,
   parameter logic [31:0] KIND = 32'h0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr,
   input  logic        sel,
   input  logic [3:0]  be,
   input  logic [31:0] wd,
   output logic [31:0] val
);

   initial begin
      if ((MASK & KIND) != 32'h0)
         $error("slot mask overlaps the type bits");
   end

   logic take;
   assign take = wr && sel && (be == 4'hF);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         val <= KIND;
      else if (take)
         val <= (val & ~MASK) | (wd & MASK);
   end

   // R5
   type_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $stable(val & ~MASK));

   // R7
   partial_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && sel && (be != 4'hF)) |=> $stable(val));

endmodule

// File: rtl/cfg_hdr_t0.sv
module cfg_hdr_t0
   import cfg_hdr_pkg::*;
#(
   parameter logic [15:0] VENDOR_ID = 16'hA5C3,
   parameter logic [15:0] DEVICE_ID = 16'h0B17,
   parameter logic [7:0]  REVISION  = 8'h02,
   parameter logic [23:0] CLASS_CODE = 24'h020000,
   parameter logic [15:0] SUB_VENDOR = 16'hA5C3,
   parameter logic [15:0] SUB_ID     = 16'h0001,
   parameter logic [7:0]  INT_PIN    = 8'h01,
   parameter bit          HAS_CAP    = 1'b1,
   parameter bar_kind_e   BAR_KIND [NBAR] = '{BK_MEM32, BK_IO, BK_MEM64, BK_NONE, BK_NONE, BK_IO},
   parameter logic [63:0] BAR_BYTES [NBAR] = '{64'd100, 64'd20, 64'd1048576, 64'd0, 64'd0, 64'd2},
   parameter logic [NBAR-1:0] BAR_PREF = 6'b000100
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_wr_en,
   input  logic [3:0]           cfg_dw_addr,
   input  logic [3:0]           cfg_byte_en,
   input  logic [31:0]          cfg_wr_data,
   output logic [31:0]          cfg_rd_data,
   input  logic [5:0]           err_evt,
   output logic [NBAR-1:0]      bar_en,
   output logic [NBAR*64-1:0]   bar_base
);

   localparam int BAR_DWN = BAR_DW0 + NBAR - 1;

   // writable mask of slot i, upper slots take the high half of their partner
   function automatic logic [31:0] slot_mask(int i);
      logic [63:0] m;
      if (BAR_KIND[i] != BK_NONE) begin
         m = span_mask(BAR_KIND[i], BAR_BYTES[i]);
         return m[31:0];
      end
      if (i > 0) begin
         if (BAR_KIND[i-1] == BK_MEM64) begin
            m = span_mask(BK_MEM64, BAR_BYTES[i-1]);
            return m[63:32];
         end
      end
      return 32'h0;
   endfunction

   logic [15:0] cmd_q;
   logic [15:0] stat_q;
   logic [31:0] bar_val [NBAR];
   logic        hdr_wr;

   assign hdr_wr = cfg_wr_en && (cfg_dw_addr == DW_AW'(1));

   cfg_cmd_stat i_cmd_stat (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (hdr_wr),
      .be      (cfg_byte_en),
      .wd      (cfg_wr_data),
      .err_evt (err_evt),
      .cmd_q   (cmd_q),
      .stat_q  (stat_q)
   );

   for (genvar i = 0; i < NBAR; i++) begin : g_slot
      localparam logic [31:0] SMASK = slot_mask(i);
      localparam logic [31:0] SKIND = kind_bits(BAR_KIND[i], BAR_PREF[i]);

      if (BAR_KIND[i] == BK_MEM64) begin : g_pair_chk
         if (i == NBAR - 1) begin : g_last
            $error("64-bit slot has no upper partner");
         end else if (BAR_KIND[i+1] != BK_NONE) begin : g_busy
            $error("upper partner of a 64-bit slot must be unused");
         end
      end

      cfg_bar_slot #(
         .MASK (SMASK),
         .KIND (SKIND)
      ) i_slot (
         .clk   (clk),
         .rst_n (rst_n),
         .wr    (cfg_wr_en),
         .sel   (cfg_dw_addr == DW_AW'(BAR_DW0 + i)),
         .be    (cfg_byte_en),
         .wd    (cfg_wr_data),
         .val   (bar_val[i])
      );

      case (BAR_KIND[i])
         BK_IO: begin : g_io
            assign bar_en[i] = cmd_q[0];
            assign bar_base[64*i +: 64] = {32'h0, bar_val[i] & ~32'h3};
         end
         BK_MEM32: begin : g_m32
            assign bar_en[i] = cmd_q[1];
            assign bar_base[64*i +: 64] = {32'h0, bar_val[i] & ~32'hF};
         end
         BK_MEM64: begin : g_m64
            assign bar_en[i] = cmd_q[1];
            assign bar_base[64*i +: 64] = {bar_val[i+1], bar_val[i] & ~32'hF};
         end
         default: begin : g_none
            assign bar_en[i] = 1'b0;
            assign bar_base[64*i +: 64] = 64'h0;
         end
      endcase

      // R9
      en_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
         bar_en[i] |-> (cmd_q[0] || cmd_q[1]));
   end

   logic [2:0] rd_idx;
   assign rd_idx = 3'(cfg_dw_addr - DW_AW'(BAR_DW0));

   always_comb begin
      cfg_rd_data = 32'h0;
      if (cfg_dw_addr >= DW_AW'(BAR_DW0) && cfg_dw_addr <= DW_AW'(BAR_DWN)) begin
         cfg_rd_data = bar_val[rd_idx];
      end else begin
         case (cfg_dw_addr)
            4'd0:  cfg_rd_data = {DEVICE_ID, VENDOR_ID};
            4'd1:  cfg_rd_data = {stat_q | {11'd0, HAS_CAP, 4'd0}, cmd_q};
            4'd2:  cfg_rd_data = {CLASS_CODE, REVISION};
            4'd11: cfg_rd_data = {SUB_ID, SUB_VENDOR};
            4'd13: cfg_rd_data = {24'd0, HAS_CAP ? CAP_START : 8'h00};
            4'd15: cfg_rd_data = {16'd0, INT_PIN, 8'h00};
            default: cfg_rd_data = 32'h0;
         endcase
      end
   end

   // R10
   rst_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (bar_en == '0));

endmodule

// File: tb/test_cfg_hdr_t0.sv
`timescale 1ns/1ps
module test_cfg_hdr_t0;
   import cfg_hdr_pkg::*;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg_wr_en = 1'b0;
   logic [3:0]       cfg_dw_addr = '0;
   logic [3:0]       cfg_byte_en = '0;
   logic [31:0]      cfg_wr_data = '0;
   logic [31:0]      cfg_rd_data;
   logic [5:0]       err_evt = '0;
   logic [NBAR-1:0]  bar_en;
   logic [NBAR*64-1:0] bar_base;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #10 clk = ~clk;

   cfg_hdr_t0 i_cfg_hdr_t0 (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_wr_en   (cfg_wr_en),
      .cfg_dw_addr (cfg_dw_addr),
      .cfg_byte_en (cfg_byte_en),
      .cfg_wr_data (cfg_wr_data),
      .cfg_rd_data (cfg_rd_data),
      .err_evt     (err_evt),
      .bar_en      (bar_en),
      .bar_base    (bar_base)
   );

   typedef struct packed {
      logic [3:0]  a;
      logic [3:0]  be;
      logic [31:0] wd;
      logic [31:0] ex;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 14;
   localparam vec_t VECS [NV] = '{
      '{4'd4,  4'hF, 32'hFFFFFFFF, 32'hFFFFF000, 8'd4},  // R4 mem32 at 4 KiB floor
      '{4'd5,  4'hF, 32'hFFFFFFFF, 32'hFFFFFFE1, 8'd4},  // R4 io 20 B -> 32 B
      '{4'd6,  4'hF, 32'hFFFFFFFF, 32'hFFF0000C, 8'd5},  // R5 mem64 prefetchable
      '{4'd7,  4'hF, 32'hFFFFFFFF, 32'hFFFFFFFF, 8'd6},  // R6 upper dword
      '{4'd8,  4'hF, 32'hFFFFFFFF, 32'h00000000, 8'd8},  // R8 unused slot
      '{4'd9,  4'hF, 32'hFFFFFFFF, 32'hFFFFFFFD, 8'd4},  // R4 io at 4 B floor
      '{4'd4,  4'hF, 32'h00000000, 32'h00000000, 8'd4},  // R4 zeros
      '{4'd4,  4'h3, 32'hFFFFFFFF, 32'h00000000, 8'd7},  // R7 partial ignored
      '{4'd4,  4'hF, 32'h1234567F, 32'h12345000, 8'd4},  // R4 mixed
      '{4'd12, 4'hF, 32'hFFFFFFFF, 32'h00000000, 8'd11}, // R11 expansion ROM
      '{4'd14, 4'hF, 32'hFFFFFFFF, 32'h00000000, 8'd11}, // R11 unimplemented
      '{4'd1,  4'hF, 32'hFFFFFFFF, 32'h00100547, 8'd1},  // R1 command mask
      '{4'd0,  4'hF, 32'hFFFFFFFF, 32'h0B17A5C3, 8'd12}, // R12 identity
      '{4'd1,  4'h3, 32'h00000000, 32'h00100000, 8'd1}   // R1 clear command
   };

   task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr_dw(input logic [3:0] a, input logic [3:0] be, input logic [31:0] d);
      @(negedge clk);
      cfg_dw_addr = a;
      cfg_byte_en = be;
      cfg_wr_data = d;
      cfg_wr_en   = 1'b1;
      @(negedge clk);
      cfg_wr_en   = 1'b0;
   endtask

   task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string tag);
      cfg_dw_addr = a;
      #1;
      chk({32'h0, cfg_rd_data}, {32'h0, exp}, tag);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R10 reset state
      rd_chk(4'd1, 32'h00100000, "R10 cmd/status after reset");
      chk({58'd0, bar_en}, 64'd0, "R10 bar_en after reset");
      rd_chk(4'd5, 32'h00000001, "R10 io slot reset value");
      // R3 capability pointer and status bit
      rd_chk(4'd13, 32'h00000040, "R3 capability pointer");
      // R12 identity dwords
      rd_chk(4'd2, 32'h02000002, "R12 class/revision");
      rd_chk(4'd11, 32'h0001A5C3, "R12 subsystem");
      rd_chk(4'd15, 32'h00000100, "R12 interrupt pin");

      for (int k = 0; k < NV; k++) begin
         wr_dw(VECS[k].a, VECS[k].be, VECS[k].wd);
         rd_chk(VECS[k].a, VECS[k].ex, $sformatf("R%0d vector %0d", VECS[k].req, k));
      end

      // R9 decode enables and base addresses
      wr_dw(4'd4, 4'hF, 32'hABCDE000);
      wr_dw(4'd5, 4'hF, 32'h0000C020);
      wr_dw(4'd6, 4'hF, 32'h80000000);
      wr_dw(4'd7, 4'hF, 32'h00000002);
      chk({58'd0, bar_en}, 64'd0, "R9 enables off with command 0");
      wr_dw(4'd1, 4'h3, 32'h00000003);
      chk({58'd0, bar_en}, {58'd0, 6'b100111}, "R9 enables mem+io");
      chk(bar_base[0 +: 64],   64'h00000000ABCDE000, "R9 base slot0");
      chk(bar_base[64 +: 64],  64'h000000000000C020, "R9 base slot1 io");
      chk(bar_base[128 +: 64], 64'h0000000280000000, "R9 base slot2 64-bit");
      chk(bar_base[192 +: 64], 64'h0, "R9 base upper slot");
      chk(bar_base[320 +: 64], 64'h00000000FFFFFFFC, "R9 base slot5 io");
      wr_dw(4'd1, 4'h3, 32'h00000002);
      chk({58'd0, bar_en}, {58'd0, 6'b000101}, "R9 enables mem only");
      wr_dw(4'd1, 4'h3, 32'h00000001);
      chk({58'd0, bar_en}, {58'd0, 6'b100010}, "R9 enables io only");

      // R2 error set and write-one-to-clear
      @(negedge clk);
      err_evt = 6'h3F;
      @(negedge clk);
      err_evt = 6'h00;
      rd_chk(4'd1, 32'hF9100001, "R2 errors set");
      wr_dw(4'd1, 4'hC, 32'h28000000);
      rd_chk(4'd1, 32'hD1100001, "R2 clear bits 13 and 11");
      wr_dw(4'd1, 4'h8, 32'h00FF0000);
      rd_chk(4'd1, 32'hD1100001, "R2 disabled byte/non-error bits");
      wr_dw(4'd1, 4'hC, 32'hFFFF0000);
      rd_chk(4'd1, 32'h00100001, "R2 clear all");
      @(negedge clk);
      err_evt     = 6'h01;
      cfg_dw_addr = 4'd1;
      cfg_byte_en = 4'hC;
      cfg_wr_data = 32'h01000000;
      cfg_wr_en   = 1'b1;
      @(negedge clk);
      cfg_wr_en   = 1'b0;
      err_evt     = 6'h00;
      rd_chk(4'd1, 32'h01100001, "R2 set wins over clear");

      // R10 reset in mid-run
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk({58'd0, bar_en}, 64'd0, "R10 bar_en after mid-run reset");
      rd_chk(4'd1, 32'h00100000, "R10 command and errors cleared");
      rd_chk(4'd4, 32'h00000000, "R10 mem slot back to type bits");
      rd_chk(4'd6, 32'h0000000C, "R10 64-bit slot back to type bits");

      finish_run();
   end

endmodule